// File: doc/BRIEF.md
# Log-Sine FM Operator Engine with Algorithm Mixer

This block computes FM operator outputs one at a time, using arithmetic in the log domain. Twenty-four operator slots are served in a fixed rotation, one slot every `DIV` master clocks. Each slot belongs to one of six four-operator channels. On each visit the slot's phase accumulator advances by the phase increment. A log-sine table turns the accumulated phase into an attenuation. The envelope attenuation is added to that value, and an exponent table with a shift stage converts the sum back into a signed linear sample.

The block announces the slot it is serving on `slot_stb`/`slot_idx`. Upstream logic answers in the same cycle with that slot's phase increment, envelope attenuation and channel algorithm. Every computed operator sample leaves on a one-cycle stream. When the fourth operator of a channel finishes, the channel output is recomputed from that channel's stored operator samples, as its algorithm selects. When `dac_en` is set, the sixth channel is bypassed.

Top module: `fmop_core`

## Requirements
- R1: After reset the slot index starts at 0. `slot_stb` pulses once every `DIV` clocks and the index advances by one per pulse, wrapping from 23 to 0. Slot s is operator (s mod 4)+1 of channel s/4. Channel numbers start at 0.
- R2: Each slot has a 20-bit phase accumulator, cleared by reset. On each served visit it adds `phase_inc` modulo 2^20. The operator phase is accumulator bits 19..10, taken after the add.
- R3: The low 9 phase bits k select the log attenuation L(k) = floor(256·(−log2(sin((2k+1)·π/1024))) + 0.5).
- R4: The index I = L(k) + `env_att` is limited to 8191. The base value is E = floor(2048·2^(−(f+1)/256) + 0.5), where f = I[7:0] and h = I[12:8]. The magnitude is E shifted right by h−2, or shifted left by 2−h when h < 2.
- R5: The operator sample is the magnitude, negated when phase bit 9 is 1. It appears on `op_val` with `op_id` = slot while `op_vld` is high. Samples appear in slot order, and each served slot produces exactly one sample.
- R6: After the sample of operator 4 of a channel, that channel's output is updated and `chan_vld`/`chan_id` pulse. The update uses the algorithm sampled with operator 4. Algorithms 0–3 output operator 4 alone. Algorithm 4 outputs operator 2 + operator 4. Algorithms 5 and 6 output operators 2+3+4. Algorithm 7 outputs the sum of all four.
- R7: The channel sum is formed at 18 bits and clamped to the signed 16-bit range. Sums inside that range are passed through exactly.
- R8: While `dac_en` is 1 when a slot of channel 5 (slots 20–23) is served, that slot's accumulator does not advance, it emits no sample, and channel 5's output holds. Serving resumes from the held phases.
- R9: During reset, `op_vld` and `chan_vld` are low, every channel output is 0, and every stored operator sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_inc | input | 20 | Phase increment of the slot being served |
| env_att | input | 10 | Envelope attenuation of the slot being served (log units, 4.8) |
| alg | input | 3 | Algorithm of the served slot's channel |
| dac_en | input | 1 | Bypass channel 5 when set |
| slot_stb | output | 1 | Slot being served this cycle |
| slot_idx | output | 5 | Index of the slot being served |
| op_vld | output | 1 | Operator sample valid |
| op_id | output | 5 | Slot index of the sample |
| op_val | output | 16 | Signed operator sample |
| chan_vld | output | 1 | Channel output updated |
| chan_id | output | 3 | Channel that was updated |
| chan_out_flat | output | 96 | Six signed 16-bit channel outputs, channel c at bits 16c+15..16c |

## Verification
The bench builds the block with its default parameters: a slot every 6 clocks, 24 slots and 20-bit accumulators. With these values a full rotation takes 144 clocks, so several rotations per stimulus pattern fit easily within the run. The increments are chosen so that phases cross the sign bit and wrap the accumulator. Both near-zero and large indices are reached, which exercises the left-shift branch and deep right shifts of the exponent stage. Every algorithm code is applied to some channel. One window with the channel-5 bypass set tests that held phases resume correctly.

// File: rtl/fmop_pkg.sv
package fmop_pkg;
    localparam int OPS     = 4;
    localparam int CHANS   = 6;
    localparam int SLOTS   = OPS * CHANS;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int CH_W    = $clog2(CHANS);
    localparam int PH_W    = 20;
    localparam int PH_BITS = 10;
    localparam int ENV_W   = 10;
    localparam int LOG_W   = 12;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 8;
    localparam int IDX_W   = 13;
    localparam int HI_W    = IDX_W - FRAC_W;
    localparam int MAG_W   = EXP_W + 3;
    localparam int OUT_W   = 16;
    localparam int SUM_W   = OUT_W + 2;
    localparam int ALG_W   = 3;
    localparam int SIN_N   = 1 << (PH_BITS - 1);
    localparam int EXP_N   = 1 << FRAC_W;
    localparam real PI     = 3.14159265358979323846;

    typedef struct packed {
        logic              vld;
        logic [SLOT_W-1:0] slot;
        logic [ALG_W-1:0]  alg;
    } op_ctx_t;

    // attenuation in 4.8 fixed point of a half-sine sample
    function automatic int sine_entry(int k);
        real s;
        s = $sin(((2.0 * k + 1.0) / (2.0 * SIN_N)) * PI);
        return int'($floor(-($ln(s) / $ln(2.0)) * 256.0 + 0.5));
    endfunction

    // fractional power of two with an 11-bit fraction
    function automatic int exp_entry(int f);
        return int'($floor($pow(2.0, -(f + 1.0) / 256.0) * 2048.0 + 0.5));
    endfunction
endpackage

// File: rtl/fmop_seq.sv
module fmop_seq
    import fmop_pkg::*;
#(
    parameter int DIV = 6
) (
    input  logic              clk,
    input  logic              rst,
    output logic              stb,
    output logic [SLOT_W-1:0] slot
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [DW-1:0] divcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            divcnt <= '0;
            slot   <= '0;
        end else begin
            divcnt <= (divcnt == DW'(DIV - 1)) ? '0 : divcnt + 1'b1;
            if (stb)
                slot <= (slot == SLOT_W'(SLOTS - 1)) ? '0 : slot + 1'b1;
        end
    end

    assign stb = (divcnt == '0);

    AST_STB_GAP: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb); // R1
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        stb |=> (slot == (($past(slot) == SLOT_W'(SLOTS - 1)) ? '0 : $past(slot) + 1'b1))); // R1
endmodule

// File: rtl/fmop_phase.sv
module fmop_phase
    import fmop_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               stb,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [PH_W-1:0]    phase_inc,
    input  logic [ENV_W-1:0]   env_att,
    input  logic [ALG_W-1:0]   alg,
    input  logic               dac_en,
    output op_ctx_t            c1,
    output logic [PH_BITS-1:0] ph1,
    output logic [ENV_W-1:0]   env1
);
    logic [PH_W-1:0] acc [SLOTS];
    logic [PH_W-1:0] nxt;
    logic            skip;

    assign skip = dac_en && (slot >= SLOT_W'((CHANS - 1) * OPS));
    assign nxt  = acc[slot] + phase_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) acc[i] <= '0;
            c1   <= '0;
            ph1  <= '0;
            env1 <= '0;
        end else begin
            c1.vld  <= stb && !skip;
            c1.slot <= slot;
            c1.alg  <= alg;
            ph1     <= nxt[PH_W-1 -: PH_BITS];
            env1    <= env_att;
            if (stb && !skip) acc[slot] <= nxt;
        end
    end

    AST_BYPASS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (stb && dac_en && slot >= SLOT_W'((CHANS - 1) * OPS)) |=> !c1.vld); // R8
endmodule

// File: rtl/fmop_logsin.sv
module fmop_logsin
    import fmop_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  op_ctx_t            c1,
    input  logic [PH_BITS-1:0] ph1,
    input  logic [ENV_W-1:0]   env1,
    output op_ctx_t            c4,
    output logic [OUT_W-1:0]   val4
);
    localparam int MAG_MAX = exp_entry(0) * 4;

    logic [LOG_W-1:0] sine_rom [SIN_N];
    logic [EXP_W-1:0] exp_rom  [EXP_N];

    for (genvar g = 0; g < SIN_N; g++) begin : g_sin
        assign sine_rom[g] = LOG_W'(sine_entry(g));
    end
    for (genvar g = 0; g < EXP_N; g++) begin : g_exp
        assign exp_rom[g] = EXP_W'(exp_entry(g));
    end

    op_ctx_t          c2, c3;
    logic             sgn2, sgn3;
    logic [ENV_W-1:0] env2;
    logic [LOG_W-1:0] log2r;
    logic [IDX_W:0]   raw;
    logic [IDX_W-1:0] idx;
    logic [HI_W-1:0]  hi3;
    logic [EXP_W-1:0] ex3;
    logic [MAG_W-1:0] ext, mag;
    logic [OUT_W-1:0] sv;

    assign raw = (IDX_W + 1)'(log2r) + (IDX_W + 1)'(env2);
    assign idx = raw[IDX_W] ? '1 : raw[IDX_W-1:0];

    always_comb begin
        ext = MAG_W'(ex3);
        if (hi3 < HI_W'(2)) mag = ext << (HI_W'(2) - hi3);
        else                mag = ext >> (hi3 - HI_W'(2));
    end
    assign sv = OUT_W'(mag);

    always_ff @(posedge clk) begin
        if (rst) begin
            c2 <= '0; c3 <= '0; c4 <= '0;
            sgn2 <= 1'b0; sgn3 <= 1'b0;
            env2 <= '0; log2r <= '0;
            hi3 <= '0; ex3 <= '0; val4 <= '0;
        end else begin
            c2    <= c1;
            sgn2  <= ph1[PH_BITS-1];
            env2  <= env1;
            log2r <= sine_rom[ph1[PH_BITS-2:0]];
            c3    <= c2;
            sgn3  <= sgn2;
            hi3   <= idx[IDX_W-1:FRAC_W];
            ex3   <= exp_rom[idx[FRAC_W-1:0]];
            c4    <= c3;
            val4  <= sgn3 ? (~sv + 1'b1) : sv;
        end
    end

    AST_MAG_BOUND: assert property (@(posedge clk) disable iff (rst)
        c4.vld |-> ($signed(val4) <= MAG_MAX && $signed(val4) >= -MAG_MAX)); // R4
endmodule

// File: rtl/fmop_mix.sv
module fmop_mix
    import fmop_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  op_ctx_t                c4,
    input  logic [OUT_W-1:0]       val4,
    output logic                   chan_vld,
    output logic [CH_W-1:0]        chan_id,
    output logic [CHANS*OUT_W-1:0] chan_out_flat
);
    logic [OUT_W-1:0] opv  [SLOTS];
    logic [OUT_W-1:0] chan [CHANS];
    logic [CH_W-1:0]  ch;
    logic signed [SUM_W-1:0] a, b, c, d, s;
    logic [OUT_W-1:0] sat;

    assign ch = c4.slot[SLOT_W-1:2];

    function automatic logic signed [SUM_W-1:0] sx(logic [OUT_W-1:0] v);
        return {{(SUM_W - OUT_W){v[OUT_W-1]}}, v};
    endfunction

    always_comb begin
        a = sx(opv[{ch, 2'd0}]);
        b = sx(opv[{ch, 2'd1}]);
        c = sx(opv[{ch, 2'd2}]);
        d = sx(val4);
        case (c4.alg)
            3'd4:       s = b + d;
            3'd5, 3'd6: s = b + c + d;
            3'd7:       s = a + b + c + d;
            default:    s = d;
        endcase
        if (s > SUM_W'(32767))       sat = 16'h7FFF;
        else if (s < -SUM_W'(32768)) sat = 16'h8000;
        else                         sat = s[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) opv[i] <= '0;
            for (int i = 0; i < CHANS; i++) chan[i] <= '0;
            chan_vld <= 1'b0;
            chan_id  <= '0;
        end else begin
            chan_vld <= 1'b0;
            if (c4.vld) begin
                opv[c4.slot] <= val4;
                if (c4.slot[1:0] == 2'd3) begin
                    chan[ch] <= sat;
                    chan_vld <= 1'b1;
                    chan_id  <= ch;
                end
            end
        end
    end

    for (genvar g = 0; g < CHANS; g++) begin : g_flat
        assign chan_out_flat[g*OUT_W +: OUT_W] = chan[g];
    end

    AST_CHAN_AFTER_OP4: assert property (@(posedge clk) disable iff (rst)
        chan_vld |-> ($past(c4.vld) && $past(c4.slot[1:0]) == 2'd3)); // R6
endmodule

// File: rtl/fmop_core.sv
module fmop_core
    import fmop_pkg::*;
#(
    parameter int DIV = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PH_W-1:0]        phase_inc,
    input  logic [ENV_W-1:0]       env_att,
    input  logic [ALG_W-1:0]       alg,
    input  logic                   dac_en,
    output logic                   slot_stb,
    output logic [SLOT_W-1:0]      slot_idx,
    output logic                   op_vld,
    output logic [SLOT_W-1:0]      op_id,
    output logic [OUT_W-1:0]       op_val,
    output logic                   chan_vld,
    output logic [CH_W-1:0]        chan_id,
    output logic [CHANS*OUT_W-1:0] chan_out_flat
);
    op_ctx_t            c1, c4;
    logic [PH_BITS-1:0] ph1;
    logic [ENV_W-1:0]   env1;

    fmop_seq #(.DIV(DIV)) u_seq (
        .clk(clk), .rst(rst), .stb(slot_stb), .slot(slot_idx)
    );

    fmop_phase u_phase (
        .clk(clk), .rst(rst), .stb(slot_stb), .slot(slot_idx),
        .phase_inc(phase_inc), .env_att(env_att), .alg(alg), .dac_en(dac_en),
        .c1(c1), .ph1(ph1), .env1(env1)
    );

    fmop_logsin u_logsin (
        .clk(clk), .rst(rst), .c1(c1), .ph1(ph1), .env1(env1),
        .c4(c4), .val4(op_val)
    );

    fmop_mix u_mix (
        .clk(clk), .rst(rst), .c4(c4), .val4(op_val),
        .chan_vld(chan_vld), .chan_id(chan_id), .chan_out_flat(chan_out_flat)
    );

    assign op_vld = c4.vld;
    assign op_id  = c4.slot;

    AST_ONE_OP_PER_SLOT: assert property (@(posedge clk) disable iff (rst)
        op_vld |=> !op_vld); // R5
endmodule

// File: tb/tb_fmop_core.sv
module tb_fmop_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] phase_inc;
    logic [9:0]  env_att;
    logic [2:0]  alg;
    logic        dac_en = 1'b0;
    logic        slot_stb;
    logic [4:0]  slot_idx;
    logic        op_vld;
    logic [4:0]  op_id;
    logic [15:0] op_val;
    logic        chan_vld;
    logic [2:0]  chan_id;
    logic [95:0] chan_out_flat;

    logic [19:0] inc_tab [24];
    logic [9:0]  env_tab [24];
    logic [2:0]  alg_tab [6];

    assign phase_inc = inc_tab[slot_idx];
    assign env_att   = env_tab[slot_idx];
    assign alg       = alg_tab[slot_idx / 4];

    fmop_core dut (.*);

    always #10 clk = ~clk;

    typedef struct { int id; int val; } item_t;
    item_t opq[$];
    item_t chq[$];
    int checks = 0, fails = 0;
    int macc [24];
    int eop  [24];
    int prev_slot = -1, since_stb = 0, hi_cnt = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_sine(int k);
        real s;
        s = $sin(((2.0 * k + 1.0) / 1024.0) * 3.14159265358979323846);
        return int'($floor(-($ln(s) / $ln(2.0)) * 256.0 + 0.5));
    endfunction

    function automatic int m_exp(int f);
        return int'($floor($pow(2.0, -(f + 1.0) / 256.0) * 2048.0 + 0.5));
    endfunction

    function automatic int m_op(int ph, int env);
        int ix, e, h, mag;
        ix = m_sine(ph & 511) + env;
        if (ix > 8191) ix = 8191;
        e = m_exp(ix & 255);
        h = ix >> 8;
        mag = (h < 2) ? (e << (2 - h)) : (e >> (h - 2));
        return (ph & 512) ? -mag : mag;
    endfunction

    function automatic int m_chan(int ch, int a);
        int s;
        case (a)
            4:       s = eop[ch*4+1] + eop[ch*4+3];
            5, 6:    s = eop[ch*4+1] + eop[ch*4+2] + eop[ch*4+3];
            7:       s = eop[ch*4] + eop[ch*4+1] + eop[ch*4+2] + eop[ch*4+3];
            default: s = eop[ch*4+3];
        endcase
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    // driver (pushes expectations) then monitor (pops and compares)
    always @(negedge clk) begin
        if (!rst && !done) begin
            since_stb++;
            if (slot_stb) begin
                int s;
                s = int'(slot_idx);
                if (prev_slot >= 0) begin
                    chk(s == (prev_slot + 1) % 24, "R1 slot order", s, (prev_slot + 1) % 24);
                    chk(since_stb == 6, "R1 strobe gap", since_stb, 6);
                end
                prev_slot = s;
                since_stb = 0;
                if (!(dac_en && s >= 20)) begin
                    int ph;
                    macc[s] = (macc[s] + int'(inc_tab[s])) & 20'hFFFFF;
                    ph = macc[s] >> 10;
                    eop[s] = m_op(ph, int'(env_tab[s]));
                    opq.push_back('{s, eop[s]});
                    if (s % 4 == 3)
                        chq.push_back('{s / 4, m_chan(s / 4, int'(alg_tab[s / 4]))});
                end
            end
            if (op_vld) begin
                if (op_id >= 5'd20) hi_cnt++;
                if (opq.size() == 0) chk(0, "R5 unexpected sample", int'(op_id), -1);
                else begin
                    item_t it;
                    it = opq.pop_front();
                    chk(int'(op_id) == it.id, "R5 sample slot", int'(op_id), it.id);
                    chk(int'($signed(op_val)) == it.val, "R2 R3 R4 R5 sample value",
                        int'($signed(op_val)), it.val);
                end
            end
            if (chan_vld) begin
                if (chq.size() == 0) chk(0, "R6 unexpected channel", int'(chan_id), -1);
                else begin
                    item_t it;
                    it = chq.pop_front();
                    chk(int'(chan_id) == it.id, "R6 channel id", int'(chan_id), it.id);
                    chk(int'($signed(chan_out_flat[chan_id*16 +: 16])) == it.val,
                        "R6 R7 channel sum", int'($signed(chan_out_flat[chan_id*16 +: 16])), it.val);
                end
            end
        end
    end

    task automatic run_rounds(int n);
        repeat (n * 144) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [15:0] ch5_hold;
        for (int i = 0; i < 24; i++) begin
            macc[i] = 0; eop[i] = 0;
            inc_tab[i] = 20'h00400 * (i + 1) + 20'(i * 37);
            env_tab[i] = 10'd0;
        end
        for (int c = 0; c < 6; c++) alg_tab[c] = 3'(c);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(op_vld == 1'b0, "R9 op_vld in reset", int'(op_vld), 0);
        chk(chan_vld == 1'b0, "R9 chan_vld in reset", int'(chan_vld), 0);
        chk(chan_out_flat == '0, "R9 channel outputs in reset", int'(chan_out_flat != '0), 0);
        chk(slot_idx == 5'd0, "R9 R1 slot index in reset", int'(slot_idx), 0);
        @(posedge clk); #1 rst = 1'b0;

        // pattern A: no attenuation, algorithms 0..5
        run_rounds(4);
        // pattern B: graded attenuation, algorithms 6,7,4,5,3,7
        for (int i = 0; i < 24; i++) begin
            inc_tab[i] = 20'h01234 * 20'(i + 3);
            env_tab[i] = 10'(i * 40);
        end
        alg_tab[0] = 3'd6; alg_tab[1] = 3'd7; alg_tab[2] = 3'd4;
        alg_tab[3] = 3'd5; alg_tab[4] = 3'd3; alg_tab[5] = 3'd7;
        run_rounds(4);

        // R8 bypass window
        dac_en = 1'b1;
        repeat (12) @(posedge clk);
        #1;
        ch5_hold = chan_out_flat[95:80];
        hi_cnt = 0;
        run_rounds(3);
        chk(hi_cnt == 0, "R8 no channel 5 samples while bypassed", hi_cnt, 0);
        chk(chan_out_flat[95:80] == ch5_hold, "R8 channel 5 output held",
            int'($signed(chan_out_flat[95:80])), int'($signed(ch5_hold)));
        dac_en = 1'b0;
        run_rounds(3);   // R8 resume from held phases, checked by scoreboard

        // pattern E: wrap-around increments, strong attenuation, all-operator sum
        for (int i = 0; i < 24; i++) begin
            inc_tab[i] = 20'hFFFFF - 20'(i * 1000);
            env_tab[i] = (i % 3 == 0) ? 10'd1023 : 10'(i * 7);
        end
        for (int c = 0; c < 6; c++) alg_tab[c] = 3'd7;
        run_rounds(3);

        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(opq.size() == 0, "R5 all expected samples seen", opq.size(), 0);
        chk(chq.size() == 0, "R6 all expected channel updates seen", chq.size(), 0);
        finish_run();
    end
endmodule